// File: doc/BRIEF.md
# Cascaded Up/Down Timer Pair

Two equal-width counters are chained so that the low half's wrap (overflow when counting up, underflow when counting down) is the only thing that advances the high half. Together they behave as one counter of twice the width. Software reaches the counters, a compare register and a buffer register through a write port with two phases. The address is presented in phase T1. The data is committed in phase T2, on the very next cycle.

Hardware events can land in the same cycle as a T2 commit, and fixed precedence rules settle these collisions. A write to the low half beats its own wrap and also cancels the carry into the high half. The compare test and every capture driven by the high half's count clock still fire on that cancelled carry. A capture into the buffered register beats a software write to the buffer. Single-cycle event inputs stand in for capture pins. One shared control bit makes a compare event clear both halves on the same edge.

Top module: `cascade_timer`

## Requirements
- R1: While `rst` is high at a clock edge, every register output and `cmp_match` are zero.
- R2: When `cnt_en` is high, the low half steps by one on each edge: up when `cnt_down` is 0, down when it is 1. It wraps between all-ones and zero.
- R3: The high half steps by one in the direction set by `cnt_down` only on an edge where the low half wraps. In every other case it keeps its value, unless it is written or cleared.
- R4: A write takes effect at the end of T2. T1 is a cycle with `bus_t1` high and the address on `bus_addr`. T2 is the next cycle, with `bus_t2` high and the data on `bus_wdata`. The address codes are 0 for the low half, 1 for the high half, 2 for the compare register and 3 for the buffer register. A `bus_t2` that does not directly follow a T1 has no effect. A write to the high half takes priority over its carry.
- R5: If the low half is written in T2 on an edge where it would wrap, the written value is loaded and the high half does not advance.
- R6: `cmp_match` is high for the cycle after every cycle in which the low half wraps while the high half equals the compare register. This includes a wrap whose carry was cancelled by R5.
- R7: With `clr_en` high, the compare event of R6 loads zero into both halves on the same edge. A bus write to a half takes priority over the clear for that half.
- R8: A `cap_buf` pulse copies the low half into `gr_q` and, on the same edge, copies the old `gr_q` into `buf_q`.
- R9: If `cap_buf` is high in the T2 cycle of a write to the buffer register, the transfer of R8 wins and the written data is discarded.
- R10: `hb_q` takes the pre-edge value of the high half when its event occurs. With `hb_sel`=0 the event is `cap_hb`. With `hb_sel`=1 the event is the compare event of R6, including the cancelled-carry cycle.
- R11: Each auxiliary capture register `i` takes the pre-edge value of the low half when its event occurs. With `aux_sel[i]`=1 the event is a low-half wrap (the high half's count clock, including the cancelled-carry cycle). With `aux_sel[i]`=0 the event is `cap_aux[i]`. Register `i` sits at `aux_q[i*CW +: CW]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Low-half count enable |
| cnt_down | input | 1 | Count direction, 1 = down |
| clr_en | input | 1 | Compare event clears both halves |
| bus_t1 | input | 1 | Write phase T1 strobe |
| bus_addr | input | 2 | Register code, valid with T1 |
| bus_t2 | input | 1 | Write phase T2 strobe |
| bus_wdata | input | CW | Write data, valid with T2 |
| cap_buf | input | 1 | Buffered capture event |
| cap_hb | input | 1 | High-half capture event |
| hb_sel | input | 1 | High-half capture source select |
| cap_aux | input | NAUX | Auxiliary capture events |
| aux_sel | input | NAUX | Auxiliary capture source selects |
| lo_q | output | CW | Low half |
| hi_q | output | CW | High half |
| cmpa_q | output | CW | Compare register |
| gr_q | output | CW | Capture general register |
| buf_q | output | CW | Capture buffer register |
| hb_q | output | CW | High-half capture register |
| aux_q | output | NAUX*CW | Auxiliary capture registers |
| cmp_match | output | 1 | Registered compare event pulse |

## Verification
The bench builds the block with CW=4 and NAUX=4. At that width the low half wraps every sixteen counts, so carries, borrows, high-half wraps and compare hits occur many times within a short run. The small width also makes it cheap to line up a wrap with a chosen T2 cycle. Each collision case is forced directly. A long random section then mixes overlapping bus phases, capture pulses and source selects against the behavioural model.

// File: rtl/ctimer_pkg.sv
package ctimer_pkg;
  typedef enum logic [1:0] {
    REG_LO   = 2'd0,
    REG_HI   = 2'd1,
    REG_CMPA = 2'd2,
    REG_BUF  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/ctimer_bus.sv
module ctimer_bus #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_t1,
  input  logic [1:0]    bus_addr,
  input  logic          bus_t2,
  input  logic [CW-1:0] bus_wdata,
  output logic          wr_lo,
  output logic          wr_hi,
  output logic          wr_cmpa,
  output logic          wr_buf,
  output logic [CW-1:0] wr_data
);
  import ctimer_pkg::*;

  logic     pend_q;
  reg_sel_e addr_q;
  logic     commit;

  // T1 latches the address; T2 is only honoured on the cycle right after it
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      addr_q <= REG_LO;
    end else begin
      pend_q <= bus_t1;
      if (bus_t1) addr_q <= reg_sel_e'(bus_addr);
    end
  end

  assign commit  = bus_t2 & pend_q;
  assign wr_lo   = commit && (addr_q == REG_LO);
  assign wr_hi   = commit && (addr_q == REG_HI);
  assign wr_cmpa = commit && (addr_q == REG_CMPA);
  assign wr_buf  = commit && (addr_q == REG_BUF);
  assign wr_data = bus_wdata;
endmodule

// File: rtl/ctimer_half.sv
module ctimer_half #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          clear,
  input  logic          step,
  input  logic          down,
  output logic [CW-1:0] q
);
  // priority: bus load, then shared clear, then count step
  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (load)  q <= load_val;
    else if (clear) q <= '0;
    else if (step)  q <= down ? q - 1'b1 : q + 1'b1;
  end
endmodule

// File: rtl/ctimer_capture.sv
module ctimer_capture #(
  parameter int CW   = 16,
  parameter int NAUX = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CW-1:0]      lo,
  input  logic [CW-1:0]      hi,
  input  logic               cap_buf,
  input  logic               wr_buf,
  input  logic [CW-1:0]      wr_data,
  input  logic               hb_evt,
  input  logic [NAUX-1:0]    aux_evt,
  output logic [CW-1:0]      gr_q,
  output logic [CW-1:0]      buf_q,
  output logic [CW-1:0]      hb_q,
  output logic [NAUX*CW-1:0] aux_q
);
  // buffered pair: a capture shifts gr into buf and beats any bus write
  always_ff @(posedge clk) begin
    if (rst) begin
      gr_q  <= '0;
      buf_q <= '0;
    end else if (cap_buf) begin
      gr_q  <= lo;
      buf_q <= gr_q;
    end else if (wr_buf) begin
      buf_q <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         hb_q <= '0;
    else if (hb_evt) hb_q <= hi;
  end

  for (genvar i = 0; i < NAUX; i++) begin : g_aux
    always_ff @(posedge clk) begin
      if (rst)             aux_q[i*CW +: CW] <= '0;
      else if (aux_evt[i]) aux_q[i*CW +: CW] <= lo;
    end
  end
endmodule

// File: rtl/cascade_timer.sv
module cascade_timer #(
  parameter int CW   = 16,
  parameter int NAUX = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cnt_en,
  input  logic               cnt_down,
  input  logic               clr_en,
  input  logic               bus_t1,
  input  logic [1:0]         bus_addr,
  input  logic               bus_t2,
  input  logic [CW-1:0]      bus_wdata,
  input  logic               cap_buf,
  input  logic               cap_hb,
  input  logic               hb_sel,
  input  logic [NAUX-1:0]    cap_aux,
  input  logic [NAUX-1:0]    aux_sel,
  output logic [CW-1:0]      lo_q,
  output logic [CW-1:0]      hi_q,
  output logic [CW-1:0]      cmpa_q,
  output logic [CW-1:0]      gr_q,
  output logic [CW-1:0]      buf_q,
  output logic [CW-1:0]      hb_q,
  output logic [NAUX*CW-1:0] aux_q,
  output logic               cmp_match
);
  localparam logic [CW-1:0] ALL_ONES = {CW{1'b1}};

  logic          wr_lo, wr_hi, wr_cmpa, wr_buf;
  logic [CW-1:0] wr_data;
  logic          lo_wrap, hi_step, cmp_ev, clr_hit, hb_evt;
  logic [NAUX-1:0] aux_evt;

  ctimer_bus #(.CW(CW)) u_bus (
    .clk(clk), .rst(rst), .bus_t1(bus_t1), .bus_addr(bus_addr),
    .bus_t2(bus_t2), .bus_wdata(bus_wdata), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .wr_cmpa(wr_cmpa), .wr_buf(wr_buf), .wr_data(wr_data)
  );

  // wrap of the low half is the high half's count clock
  assign lo_wrap = cnt_en & (cnt_down ? (lo_q == '0) : (lo_q == ALL_ONES));
  // a low-half write in T2 cancels the carry pulse
  assign hi_step = lo_wrap & ~wr_lo;
  // compare is judged on the count clock even when its carry is cancelled
  assign cmp_ev  = lo_wrap & (hi_q == cmpa_q);
  assign clr_hit = clr_en & cmp_ev;

  ctimer_half #(.CW(CW)) u_lo (
    .clk(clk), .rst(rst), .load(wr_lo), .load_val(wr_data),
    .clear(clr_hit), .step(cnt_en), .down(cnt_down), .q(lo_q)
  );

  ctimer_half #(.CW(CW)) u_hi (
    .clk(clk), .rst(rst), .load(wr_hi), .load_val(wr_data),
    .clear(clr_hit), .step(hi_step), .down(cnt_down), .q(hi_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmpa_q    <= '0;
      cmp_match <= 1'b0;
    end else begin
      if (wr_cmpa) cmpa_q <= wr_data;
      cmp_match <= cmp_ev;
    end
  end

  assign hb_evt  = hb_sel ? cmp_ev : cap_hb;
  assign aux_evt = (aux_sel & {NAUX{lo_wrap}}) | (~aux_sel & cap_aux);

  ctimer_capture #(.CW(CW), .NAUX(NAUX)) u_cap (
    .clk(clk), .rst(rst), .lo(lo_q), .hi(hi_q), .cap_buf(cap_buf),
    .wr_buf(wr_buf), .wr_data(wr_data), .hb_evt(hb_evt), .aux_evt(aux_evt),
    .gr_q(gr_q), .buf_q(buf_q), .hb_q(hb_q), .aux_q(aux_q)
  );
endmodule

// File: rtl/ctimer_chk.sv
module ctimer_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_lo,
  input logic          wr_hi,
  input logic [CW-1:0] wr_data,
  input logic          lo_wrap,
  input logic          cmp_ev,
  input logic          clr_hit,
  input logic          cap_buf,
  input logic [CW-1:0] lo_q,
  input logic [CW-1:0] hi_q,
  input logic [CW-1:0] gr_q,
  input logic [CW-1:0] buf_q,
  input logic          cmp_match
);
  p_hi_holds_r3: assert property (@(posedge clk) disable iff (rst)
    (!lo_wrap && !wr_hi && !clr_hit) |=> $stable(hi_q));

  p_lo_write_wins_r5: assert property (@(posedge clk) disable iff (rst)
    wr_lo |=> (lo_q == $past(wr_data)));

  p_carry_cancelled_r5: assert property (@(posedge clk) disable iff (rst)
    (lo_wrap && wr_lo && !wr_hi && !clr_hit) |=> $stable(hi_q));

  p_match_follows_r6: assert property (@(posedge clk) disable iff (rst)
    cmp_ev |=> cmp_match);

  p_match_only_r6: assert property (@(posedge clk) disable iff (rst)
    !cmp_ev |=> !cmp_match);

  p_clear_both_r7: assert property (@(posedge clk) disable iff (rst)
    (clr_hit && !wr_lo && !wr_hi) |=> (lo_q == '0 && hi_q == '0));

  p_gr_capture_r8: assert property (@(posedge clk) disable iff (rst)
    cap_buf |=> (gr_q == $past(lo_q)));

  p_buf_transfer_wins_r9: assert property (@(posedge clk) disable iff (rst)
    cap_buf |=> (buf_q == $past(gr_q)));
endmodule

bind cascade_timer ctimer_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data),
  .lo_wrap(lo_wrap), .cmp_ev(cmp_ev), .clr_hit(clr_hit), .cap_buf(cap_buf),
  .lo_q(lo_q), .hi_q(hi_q), .gr_q(gr_q), .buf_q(buf_q), .cmp_match(cmp_match)
);

// File: tb/cascade_timer_tb.sv
module cascade_timer_tb;
  localparam int CW   = 4;
  localparam int NAUX = 4;
  localparam int MASK = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cnt_en = 0, cnt_down = 0, clr_en = 0;
  logic bus_t1 = 0, bus_t2 = 0;
  logic [1:0] bus_addr = '0;
  logic [CW-1:0] bus_wdata = '0;
  logic cap_buf = 0, cap_hb = 0, hb_sel = 0;
  logic [NAUX-1:0] cap_aux = '0, aux_sel = '0;
  logic [CW-1:0] lo_q, hi_q, cmpa_q, gr_q, buf_q, hb_q;
  logic [NAUX*CW-1:0] aux_q;
  logic cmp_match;

  int nchk = 0, nfail = 0;
  bit done = 0;

  // behavioural reference state
  int m_lo, m_hi, m_cmpa, m_gr, m_buf, m_hb, m_match, m_pend, m_paddr;
  int m_aux[NAUX];

  always #5 clk = ~clk;

  cascade_timer #(.CW(CW), .NAUX(NAUX)) u_dut (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .cnt_down(cnt_down), .clr_en(clr_en),
    .bus_t1(bus_t1), .bus_addr(bus_addr), .bus_t2(bus_t2), .bus_wdata(bus_wdata),
    .cap_buf(cap_buf), .cap_hb(cap_hb), .hb_sel(hb_sel), .cap_aux(cap_aux),
    .aux_sel(aux_sel), .lo_q(lo_q), .hi_q(hi_q), .cmpa_q(cmpa_q), .gr_q(gr_q),
    .buf_q(buf_q), .hb_q(hb_q), .aux_q(aux_q), .cmp_match(cmp_match)
  );

  task automatic chk(string tag, string what, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_lo = 0; m_hi = 0; m_cmpa = 0; m_gr = 0; m_buf = 0; m_hb = 0;
    m_match = 0; m_pend = 0; m_paddr = 0;
    foreach (m_aux[i]) m_aux[i] = 0;
  endtask

  task automatic model_next();
    int commit, wrap, ev, clr, nlo, nhi, d;
    d = int'(bus_wdata);
    commit = (bus_t2 && m_pend) ? 1 : 0;
    wrap = cnt_en && (cnt_down ? (m_lo == 0) : (m_lo == MASK));
    ev = wrap && (m_hi == m_cmpa);
    clr = clr_en && ev;
    if (commit && m_paddr == 0) nlo = d;
    else if (clr) nlo = 0;
    else if (cnt_en) nlo = cnt_down ? (m_lo + MASK) & MASK : (m_lo + 1) & MASK;
    else nlo = m_lo;
    if (commit && m_paddr == 1) nhi = d;
    else if (clr) nhi = 0;
    else if (wrap && !(commit && m_paddr == 0))
      nhi = cnt_down ? (m_hi + MASK) & MASK : (m_hi + 1) & MASK;
    else nhi = m_hi;
    if (commit && m_paddr == 2) m_cmpa = d;
    if (cap_buf) begin m_buf = m_gr; m_gr = m_lo; end
    else if (commit && m_paddr == 3) m_buf = d;
    if (hb_sel ? ev : cap_hb) m_hb = m_hi;
    for (int i = 0; i < NAUX; i++)
      if (aux_sel[i] ? wrap : cap_aux[i]) m_aux[i] = m_lo;
    m_match = ev;
    m_lo = nlo; m_hi = nhi;
    m_pend = bus_t1; if (bus_t1) m_paddr = int'(bus_addr);
  endtask

  task automatic compare_all();
    chk("R2", "lo_q", lo_q, m_lo);
    chk("R3", "hi_q", hi_q, m_hi);
    chk("R4", "cmpa_q", cmpa_q, m_cmpa);
    chk("R8", "gr_q", gr_q, m_gr);
    chk("R9", "buf_q", buf_q, m_buf);
    chk("R10", "hb_q", hb_q, m_hb);
    chk("R6", "cmp_match", cmp_match, m_match);
    for (int i = 0; i < NAUX; i++) chk("R11", "aux_q", aux_q[i*CW +: CW], m_aux[i]);
  endtask

  task automatic step();
    model_next();
    @(posedge clk); #2;
    compare_all();
    bus_t1 = 0; bus_t2 = 0; cap_buf = 0; cap_hb = 0; cap_aux = '0;
  endtask

  task automatic bus_write(int a, int d);
    bus_t1 = 1; bus_addr = 2'(a); step();
    bus_t2 = 1; bus_wdata = CW'(d); step();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog act=hung exp=finished");
    finish_run();
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state
    compare_all();
    chk("R1", "lo_q reset", lo_q, 0);
    chk("R1", "cmp_match reset", cmp_match, 0);
    rst = 0;

    // R2 R3: count up across several low-half wraps
    cnt_en = 1;
    repeat (40) step();
    chk("R3", "hi after 40 up", hi_q, 2);

    // R2 R3: count down across borrows
    cnt_down = 1;
    repeat (45) step();
    cnt_en = 0; cnt_down = 0;

    // R4: set up registers for the collision
    bus_write(2, 2);
    bus_write(1, 2);
    bus_write(0, MASK);
    chk("R4", "cmpa write", cmpa_q, 2);

    // R5 R6 R10 R11: low write in T2 collides with its wrap
    hb_sel = 1; aux_sel = 4'b0001;
    bus_t1 = 1; bus_addr = 2'd0; step();
    cnt_en = 1; bus_t2 = 1; bus_wdata = 4'd5; step();
    cnt_en = 0;
    chk("R5", "lo loaded in collision", lo_q, 5);
    chk("R5", "hi carry cancelled", hi_q, 2);
    chk("R6", "match on cancelled carry", cmp_match, 1);
    chk("R10", "hb on cancelled carry", hb_q, 2);
    chk("R11", "aux0 on cancelled carry", aux_q[CW-1:0], MASK);
    step();
    chk("R6", "match one cycle", cmp_match, 0);

    // R7: compare event clears both halves
    bus_write(0, MASK);
    clr_en = 1; cnt_en = 1; step();
    chk("R7", "lo cleared", lo_q, 0);
    chk("R7", "hi cleared", hi_q, 0);
    clr_en = 0; cnt_en = 0;

    // R8 R9: buffered capture and its collision with a buffer write
    bus_write(0, 7);
    cap_buf = 1; step();
    chk("R8", "gr captured", gr_q, 7);
    bus_write(0, 9);
    bus_t1 = 1; bus_addr = 2'd3; step();
    bus_t2 = 1; bus_wdata = 4'd12; cap_buf = 1; step();
    chk("R9", "buf takes old gr", buf_q, 7);
    chk("R8", "gr new", gr_q, 9);
    bus_write(3, 12);
    chk("R4", "buf write alone", buf_q, 12);

    // R4: T2 without a preceding T1 is ignored
    bus_t2 = 1; bus_wdata = 4'd11; step();
    chk("R4", "orphan T2", cmpa_q, 2);

    // R10 R11: pulse-driven captures
    hb_sel = 0; aux_sel = '0;
    cap_hb = 1; cap_aux = 4'b1010; step();
    chk("R10", "hb pulse", hb_q, hi_q);

    // mixed random traffic
    for (int n = 0; n < 4000; n++) begin
      if (n % 64 == 0) begin
        hb_sel = 1'($urandom); aux_sel = NAUX'($urandom);
        cnt_down = 1'($urandom); clr_en = ($urandom % 4) == 0;
      end
      cnt_en = ($urandom % 4) != 0;
      bus_t1 = ($urandom % 3) == 0; bus_addr = 2'($urandom);
      bus_t2 = ($urandom % 2) == 0; bus_wdata = CW'($urandom);
      cap_buf = ($urandom % 8) == 0; cap_hb = ($urandom % 8) == 0;
      cap_aux = NAUX'($urandom) & NAUX'($urandom);
      step();
    end
    finish_run();
  end
endmodule